// File: doc/BRIEF.md
# Boot Script Interpreter Engine

A small sequencer that runs a fixed-format boot script out of a byte-addressed ROM window. Every instruction is nine bytes long: an opcode byte, then two 32-bit little-endian operands. The engine fetches the instruction one byte at a time, decodes it, and then does one of three things. It computes a new value in its accumulator or scratch register, or it takes a relative branch, or it performs one access on one of three request ports.

The three ports are a dword memory port, a byte I/O port, and an indirect configuration port. The configuration port has an address register and a data register. The engine has no decoder for the script's side effects; it only issues the accesses.

A one-cycle start pulse loads the entry address and clears both working registers. The exit opcode halts the engine and raises a done flag. That flag stays high until the next start. While a script is running, start is ignored.

Top module: `boot_script_engine`

## Requirements
- R1: A start pulse in idle or done sets the program counter to 0xFF000080 and clears the accumulator and scratch to zero. Each instruction is fetched as nine consecutive ROM byte reads at pc..pc+8. Byte 0 is the opcode, bytes 1..4 are operand A (least significant byte first), and bytes 5..8 are operand B.
- R2: After every instruction the pc advances by 9. Opcode 0x09 also adds operand B. Opcode 0x08 adds operand B only when the accumulator differs from operand A. The addition is modulo 2^32, so a negative B branches backwards.
- R3: Opcode 0x02 reads the memory port at operand A with its top four bits cleared and loads the result into the accumulator. Opcode 0x03 writes operand B to memory address operand A.
- R4: Opcode 0x04 makes two writes on the configuration port. The first writes operand A to the address register (sel=0). The second writes operand B to the data register (sel=1). When operand A is 0x80000880, bit 1 of the data written is forced to 0.
- R5: Opcode 0x05 writes operand A to the configuration address register. It then reads the data register (sel=1, we=0) into the accumulator.
- R6: Opcode 0x06 sets acc = (acc & A) | B. Opcode 0x10 sets scratch = (scratch & A) | B and then copies scratch into acc.
- R7: Opcode 0x11 writes the low byte of B to I/O port A[15:0]. Opcode 0x12 reads a byte from I/O port A[15:0] into the accumulator, zero-extended.
- R8: Opcode 0x07 is a prefix. The effective opcode is the low byte of A, the effective A is B, and the effective B is the current accumulator. The effective instruction then runs under R2 to R7.
- R9: Opcode 0xEE stops the engine. The engine then raises done_o and issues no request until the next start. Every other undefined opcode only advances the pc. After reset, done_o is low and no request is raised.
- R10: At most one request is raised at a time. A request keeps its address and write data stable until it is acknowledged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start pulse, taken in idle or done |
| done_o | output | 1 | Exit opcode reached |
| rom_req_o | output | 1 | ROM byte read request |
| rom_addr_o | output | 32 | ROM byte address |
| rom_ack_i | input | 1 | ROM byte valid |
| rom_data_i | input | 8 | ROM byte |
| mem_req_o | output | 1 | Memory request |
| mem_we_o | output | 1 | Memory write when high |
| mem_addr_o | output | 32 | Memory address |
| mem_wdata_o | output | 32 | Memory write data |
| mem_ack_i | input | 1 | Memory acknowledge |
| mem_rdata_i | input | 32 | Memory read data |
| cfg_req_o | output | 1 | Configuration port request |
| cfg_we_o | output | 1 | Configuration write when high |
| cfg_sel_o | output | 1 | 0 address register, 1 data register |
| cfg_wdata_o | output | 32 | Configuration write data |
| cfg_ack_i | input | 1 | Configuration acknowledge |
| cfg_rdata_i | input | 32 | Configuration read data |
| io_req_o | output | 1 | Byte I/O request |
| io_we_o | output | 1 | I/O write when high |
| io_addr_o | output | 16 | I/O port number |
| io_wdata_o | output | 8 | I/O write byte |
| io_ack_i | input | 1 | I/O acknowledge |
| io_rdata_i | input | 8 | I/O read byte |

## Verification
A ROM byte is consumed at the clock edge where its acknowledge is high. The next byte address appears on the following cycle. One decode cycle separates the ninth byte from the access request or the next fetch. A read result lands in the accumulator at the acknowledge edge, so it is only visible through a later instruction: a prefixed write or a conditional branch. The bench therefore compares the design against a behavioural interpreter one handshake at a time. It drives each acknowledge on the falling edge, with a latency of zero to two cycles. At that falling edge it pops the expected transaction and checks kind, address and data. Request stability is checked at every falling edge while a request waits.

// File: rtl/bse_pkg.sv
package bse_pkg;
  localparam int unsigned INSTR_BYTES = 9;
  localparam int unsigned INSTR_W     = INSTR_BYTES * 8;

  localparam logic [7:0] OP_MEM_RD = 8'h02;
  localparam logic [7:0] OP_MEM_WR = 8'h03;
  localparam logic [7:0] OP_CFG_WR = 8'h04;
  localparam logic [7:0] OP_CFG_RD = 8'h05;
  localparam logic [7:0] OP_ACC_AO = 8'h06;
  localparam logic [7:0] OP_PREFIX = 8'h07;
  localparam logic [7:0] OP_JNE    = 8'h08;
  localparam logic [7:0] OP_JMP    = 8'h09;
  localparam logic [7:0] OP_SCR_AO = 8'h10;
  localparam logic [7:0] OP_IO_WR  = 8'h11;
  localparam logic [7:0] OP_IO_RD  = 8'h12;
  localparam logic [7:0] OP_EXIT   = 8'hEE;

  typedef enum logic [3:0] {
    ACT_NOP, ACT_MEM_RD, ACT_MEM_WR, ACT_CFG_WR, ACT_CFG_RD, ACT_ACC,
    ACT_SCR, ACT_JNE, ACT_JMP, ACT_IO_WR, ACT_IO_RD, ACT_EXIT
  } act_e;

  typedef enum logic [3:0] {
    ST_IDLE, ST_FETCH, ST_EXEC, ST_MEM_RD, ST_MEM_WR, ST_CFG_ADR,
    ST_CFG_WR, ST_CFG_RD, ST_IO_WR, ST_IO_RD, ST_DONE
  } state_e;
endpackage

// File: rtl/bse_fetch_buf.sv
module bse_fetch_buf #(
  parameter int unsigned N_BYTES = 9,
  localparam int unsigned IDX_W = $clog2(N_BYTES)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 clr_i,
  input  logic                 wr_i,
  input  logic [7:0]           data_i,
  output logic [IDX_W-1:0]     idx_o,
  output logic                 last_o,
  output logic [N_BYTES*8-1:0] buf_o
);
  logic [IDX_W-1:0] idx_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     idx_q <= '0;
    else if (clr_i)  idx_q <= '0;
    else if (wr_i)   idx_q <= idx_q + 1'b1;
  end

  for (genvar g = 0; g < N_BYTES; g++) begin : g_byte
    logic [7:0] b_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                             b_q <= '0;
      else if (wr_i && idx_q == IDX_W'(g))     b_q <= data_i;
    end
    assign buf_o[g*8 +: 8] = b_q;
  end

  assign idx_o  = idx_q;
  assign last_o = (idx_q == IDX_W'(N_BYTES - 1));
endmodule

// File: rtl/bse_decode.sv
module bse_decode
  import bse_pkg::*;
#(
  parameter logic [31:0] MEM_MASK  = 32'h0FFF_FFFF,
  parameter logic [31:0] PROT_ADDR = 32'h8000_0880,
  parameter int unsigned PROT_BIT  = 1
) (
  input  logic [INSTR_W-1:0] instr_i,
  input  logic [31:0]        acc_i,
  output act_e               act_o,
  output logic [31:0]        opa_o,
  output logic [31:0]        opb_o
);
  logic [7:0]  op;
  logic [31:0] a, b;

  always_comb begin
    op = instr_i[7:0];
    a  = instr_i[39:8];
    b  = instr_i[71:40];
    if (op == OP_PREFIX) begin
      op = a[7:0];
      a  = b;
      b  = acc_i;
    end
    case (op)
      OP_MEM_RD: act_o = ACT_MEM_RD;
      OP_MEM_WR: act_o = ACT_MEM_WR;
      OP_CFG_WR: act_o = ACT_CFG_WR;
      OP_CFG_RD: act_o = ACT_CFG_RD;
      OP_ACC_AO: act_o = ACT_ACC;
      OP_JNE:    act_o = ACT_JNE;
      OP_JMP:    act_o = ACT_JMP;
      OP_SCR_AO: act_o = ACT_SCR;
      OP_IO_WR:  act_o = ACT_IO_WR;
      OP_IO_RD:  act_o = ACT_IO_RD;
      OP_EXIT:   act_o = ACT_EXIT;
      default:   act_o = ACT_NOP;
    endcase
    if (act_o == ACT_MEM_RD) a = a & MEM_MASK;
    // protected config register: one bit may never be set by the script
    if (act_o == ACT_CFG_WR && a == PROT_ADDR) b[PROT_BIT] = 1'b0;
    opa_o = a;
    opb_o = b;
  end
endmodule

// File: rtl/bse_alu.sv
module bse_alu
  import bse_pkg::*;
(
  input  act_e        act_i,
  input  logic [31:0] opa_i,
  input  logic [31:0] opb_i,
  input  logic [31:0] acc_i,
  input  logic [31:0] scr_i,
  input  logic [31:0] pc_i,
  output logic [31:0] acc_o,
  output logic [31:0] scr_o,
  output logic [31:0] pc_o
);
  logic        take;
  logic [31:0] pc_seq;

  assign pc_seq = pc_i + 32'(INSTR_BYTES);
  assign take   = (act_i == ACT_JMP) || (act_i == ACT_JNE && acc_i != opa_i);
  assign pc_o   = take ? pc_seq + opb_i : pc_seq;

  always_comb begin
    acc_o = acc_i;
    scr_o = scr_i;
    case (act_i)
      ACT_ACC: acc_o = (acc_i & opa_i) | opb_i;
      ACT_SCR: begin
        scr_o = (scr_i & opa_i) | opb_i;
        acc_o = scr_o;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/boot_script_engine.sv
module boot_script_engine
  import bse_pkg::*;
#(
  parameter logic [31:0] PC_RESET  = 32'hFF00_0080,
  parameter logic [31:0] MEM_MASK  = 32'h0FFF_FFFF,
  parameter logic [31:0] PROT_ADDR = 32'h8000_0880,
  parameter int unsigned PROT_BIT  = 1,
  parameter int unsigned IO_ADDR_W = 16
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 start_i,
  output logic                 done_o,
  output logic                 rom_req_o,
  output logic [31:0]          rom_addr_o,
  input  logic                 rom_ack_i,
  input  logic [7:0]           rom_data_i,
  output logic                 mem_req_o,
  output logic                 mem_we_o,
  output logic [31:0]          mem_addr_o,
  output logic [31:0]          mem_wdata_o,
  input  logic                 mem_ack_i,
  input  logic [31:0]          mem_rdata_i,
  output logic                 cfg_req_o,
  output logic                 cfg_we_o,
  output logic                 cfg_sel_o,
  output logic [31:0]          cfg_wdata_o,
  input  logic                 cfg_ack_i,
  input  logic [31:0]          cfg_rdata_i,
  output logic                 io_req_o,
  output logic                 io_we_o,
  output logic [IO_ADDR_W-1:0] io_addr_o,
  output logic [7:0]           io_wdata_o,
  input  logic                 io_ack_i,
  input  logic [7:0]           io_rdata_i
);
  localparam int unsigned IDX_W = $clog2(INSTR_BYTES);

  state_e              state_q;
  logic [31:0]         pc_q, acc_q, scr_q, opa_q, opb_q;
  act_e                act_q;
  logic                done_q;
  logic                start_ok, fb_clr, fb_wr, fb_last;
  logic [IDX_W-1:0]    fb_idx;
  logic [INSTR_W-1:0]  instr;
  act_e                dec_act;
  logic [31:0]         dec_a, dec_b, alu_acc, alu_scr, alu_pc, pc_seq;

  assign start_ok = start_i && (state_q == ST_IDLE || state_q == ST_DONE);
  assign fb_clr   = start_ok || (state_q == ST_EXEC);
  assign fb_wr    = (state_q == ST_FETCH) && rom_ack_i;
  assign pc_seq   = pc_q + 32'(INSTR_BYTES);

  bse_fetch_buf #(.N_BYTES(INSTR_BYTES)) u_fetch (
    .clk_i, .rst_ni, .clr_i(fb_clr), .wr_i(fb_wr), .data_i(rom_data_i),
    .idx_o(fb_idx), .last_o(fb_last), .buf_o(instr)
  );

  bse_decode #(.MEM_MASK(MEM_MASK), .PROT_ADDR(PROT_ADDR), .PROT_BIT(PROT_BIT)) u_dec (
    .instr_i(instr), .acc_i(acc_q), .act_o(dec_act), .opa_o(dec_a), .opb_o(dec_b)
  );

  bse_alu u_alu (
    .act_i(dec_act), .opa_i(dec_a), .opb_i(dec_b), .acc_i(acc_q), .scr_i(scr_q),
    .pc_i(pc_q), .acc_o(alu_acc), .scr_o(alu_scr), .pc_o(alu_pc)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      pc_q    <= '0;
      acc_q   <= '0;
      scr_q   <= '0;
      opa_q   <= '0;
      opb_q   <= '0;
      act_q   <= ACT_NOP;
      done_q  <= 1'b0;
    end else begin
      case (state_q)
        ST_IDLE, ST_DONE: if (start_ok) begin
          pc_q    <= PC_RESET;
          acc_q   <= '0;
          scr_q   <= '0;
          done_q  <= 1'b0;
          state_q <= ST_FETCH;
        end
        ST_FETCH: if (rom_ack_i && fb_last) state_q <= ST_EXEC;
        ST_EXEC: begin
          act_q <= dec_act;
          opa_q <= dec_a;
          opb_q <= dec_b;
          case (dec_act)
            ACT_MEM_RD: state_q <= ST_MEM_RD;
            ACT_MEM_WR: state_q <= ST_MEM_WR;
            ACT_CFG_WR, ACT_CFG_RD: state_q <= ST_CFG_ADR;
            ACT_IO_WR:  state_q <= ST_IO_WR;
            ACT_IO_RD:  state_q <= ST_IO_RD;
            ACT_EXIT: begin
              done_q  <= 1'b1;
              state_q <= ST_DONE;
            end
            default: begin
              acc_q   <= alu_acc;
              scr_q   <= alu_scr;
              pc_q    <= alu_pc;
              state_q <= ST_FETCH;
            end
          endcase
        end
        ST_MEM_RD: if (mem_ack_i) begin
          acc_q   <= mem_rdata_i;
          pc_q    <= pc_seq;
          state_q <= ST_FETCH;
        end
        ST_MEM_WR, ST_CFG_WR, ST_IO_WR:
          if (mem_ack_i || cfg_ack_i || io_ack_i) begin
            pc_q    <= pc_seq;
            state_q <= ST_FETCH;
          end
        ST_CFG_ADR: if (cfg_ack_i)
          state_q <= (act_q == ACT_CFG_RD) ? ST_CFG_RD : ST_CFG_WR;
        ST_CFG_RD: if (cfg_ack_i) begin
          acc_q   <= cfg_rdata_i;
          pc_q    <= pc_seq;
          state_q <= ST_FETCH;
        end
        ST_IO_RD: if (io_ack_i) begin
          acc_q   <= {24'h0, io_rdata_i};
          pc_q    <= pc_seq;
          state_q <= ST_FETCH;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign done_o      = done_q;
  assign rom_req_o   = (state_q == ST_FETCH);
  assign rom_addr_o  = pc_q + {{(32-IDX_W){1'b0}}, fb_idx};
  assign mem_req_o   = (state_q == ST_MEM_RD) || (state_q == ST_MEM_WR);
  assign mem_we_o    = (state_q == ST_MEM_WR);
  assign mem_addr_o  = opa_q;
  assign mem_wdata_o = opb_q;
  assign cfg_req_o   = (state_q == ST_CFG_ADR) || (state_q == ST_CFG_WR) || (state_q == ST_CFG_RD);
  assign cfg_we_o    = (state_q != ST_CFG_RD);
  assign cfg_sel_o   = (state_q != ST_CFG_ADR);
  assign cfg_wdata_o = (state_q == ST_CFG_ADR) ? opa_q : opb_q;
  assign io_req_o    = (state_q == ST_IO_WR) || (state_q == ST_IO_RD);
  assign io_we_o     = (state_q == ST_IO_WR);
  assign io_addr_o   = opa_q[IO_ADDR_W-1:0];
  assign io_wdata_o  = opb_q[7:0];

  // address register value as seen on the port, for the protected-bit check
  logic [31:0] cfg_adr_seen_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cfg_adr_seen_q <= '0;
    else if (cfg_req_o && cfg_ack_i && !cfg_sel_o) cfg_adr_seen_q <= cfg_wdata_o;
  end

  AST_ONE_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({rom_req_o, mem_req_o, cfg_req_o, io_req_o})); // R10
  AST_ROM_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rom_req_o && !rom_ack_i |=> rom_req_o && $stable(rom_addr_o)); // R10
  AST_MEM_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && !mem_ack_i |=> mem_req_o && $stable(mem_addr_o) && $stable(mem_wdata_o)); // R10
  AST_FETCH_SEQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rom_req_o && rom_ack_i && !fb_last |=> rom_req_o && rom_addr_o == $past(rom_addr_o) + 32'd1); // R1
  AST_CFG_ADR_FIRST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(cfg_req_o) |-> !cfg_sel_o); // R4
  AST_PROT_BIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_req_o && cfg_sel_o && cfg_we_o && cfg_adr_seen_q == PROT_ADDR |-> !cfg_wdata_o[PROT_BIT]); // R4
  AST_DONE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !(rom_req_o || mem_req_o || cfg_req_o || io_req_o)); // R9
endmodule

// File: tb/boot_script_engine_tb.sv
module boot_script_engine_tb;
  localparam logic [31:0] B = 32'hFF00_0080;

  typedef struct { int k; logic [31:0] a; logic [31:0] d; } txn_t;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic done, rom_req, rom_ack = 0, mem_req, mem_we, mem_ack = 0;
  logic cfg_req, cfg_we, cfg_sel, cfg_ack = 0, io_req, io_we, io_ack = 0;
  logic [31:0] rom_addr, mem_addr, mem_wdata, mem_rdata = 0, cfg_wdata, cfg_rdata = 0;
  logic [7:0]  rom_data = 0, io_wdata, io_rdata = 0;
  logic [15:0] io_addr;

  always #10 clk = ~clk;

  boot_script_engine u_dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .done_o(done),
    .rom_req_o(rom_req), .rom_addr_o(rom_addr), .rom_ack_i(rom_ack), .rom_data_i(rom_data),
    .mem_req_o(mem_req), .mem_we_o(mem_we), .mem_addr_o(mem_addr), .mem_wdata_o(mem_wdata),
    .mem_ack_i(mem_ack), .mem_rdata_i(mem_rdata),
    .cfg_req_o(cfg_req), .cfg_we_o(cfg_we), .cfg_sel_o(cfg_sel), .cfg_wdata_o(cfg_wdata),
    .cfg_ack_i(cfg_ack), .cfg_rdata_i(cfg_rdata),
    .io_req_o(io_req), .io_we_o(io_we), .io_addr_o(io_addr), .io_wdata_o(io_wdata),
    .io_ack_i(io_ack), .io_rdata_i(io_rdata)
  );

  int n_chk = 0, n_fail = 0, cyc = 0;
  string tag = "R9";
  logic [7:0] rom [logic [31:0]];
  txn_t exp_q[$];
  logic [31:0] cfg_last = 0;

  task automatic chk(input bit ok, input string t, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h", t, what, act, exp);
    end
  endtask

  function automatic logic [7:0] romb(input logic [31:0] a);
    return rom.exists(a) ? rom[a] : 8'hEE;
  endfunction
  function automatic logic [31:0] mresp(input logic [31:0] a); return a ^ 32'h5EED_1234; endfunction
  function automatic logic [31:0] cresp(input logic [31:0] a); return ~a + 32'h11; endfunction
  function automatic logic [7:0]  iresp(input logic [15:0] p); return p[7:0] ^ 8'hC3; endfunction

  task automatic put(input logic [31:0] at, input logic [7:0] op, input logic [31:0] a, input logic [31:0] b);
    rom[at] = op;
    for (int k = 0; k < 4; k++) begin
      rom[at + 32'(1 + k)] = a[8*k +: 8];
      rom[at + 32'(5 + k)] = b[8*k +: 8];
    end
  endtask

  task automatic push(input int k, input logic [31:0] a, input logic [31:0] d);
    txn_t t;
    t.k = k; t.a = a; t.d = d;
    exp_q.push_back(t);
  endtask

  // behavioural interpreter producing the expected handshake sequence
  task automatic build_expected();
    logic [31:0] pc = B, acc = 0, scr = 0, a, b, cl = 0;
    logic [7:0] op;
    exp_q.delete();
    for (int step = 0; step < 256; step++) begin
      logic [7:0] by [9];
      for (int k = 0; k < 9; k++) begin
        by[k] = romb(pc + 32'(k));
        push(0, pc + 32'(k), 0);
      end
      op = by[0];
      a = {by[4], by[3], by[2], by[1]};
      b = {by[8], by[7], by[6], by[5]};
      if (op == 8'h07) begin op = a[7:0]; a = b; b = acc; end
      if (op == 8'hEE) break;
      case (op)
        8'h02: begin push(1, a & 32'h0FFF_FFFF, 0); acc = mresp(a & 32'h0FFF_FFFF); end
        8'h03: push(2, a, b);
        8'h04: begin if (a == 32'h8000_0880) b[1] = 1'b0; push(3, 0, a); push(4, 0, b); cl = a; end
        8'h05: begin push(3, 0, a); push(5, 0, 0); cl = a; acc = cresp(cl); end
        8'h06: acc = (acc & a) | b;
        8'h10: begin scr = (scr & a) | b; acc = scr; end
        8'h08: if (acc != a) pc = pc + b;
        8'h09: pc = pc + b;
        8'h11: push(6, {16'h0, a[15:0]}, {24'h0, b[7:0]});
        8'h12: begin push(7, {16'h0, a[15:0]}, 0); acc = {24'h0, iresp(a[15:0])}; end
        default: ;
      endcase
      pc = pc + 32'd9;
    end
  endtask

  // responder: acks on falling edges, compares each handshake to the model
  int lat = 0, wcnt = 0;
  bit pend = 0;
  int pend_k;
  logic [31:0] pend_a;
  always @(negedge clk) begin
    if (rst_n) begin
      int nreq, k;
      logic [31:0] a, d;
      nreq = int'(rom_req) + int'(mem_req) + int'(cfg_req) + int'(io_req);
      k = rom_req ? 0 : mem_req ? (mem_we ? 2 : 1) : cfg_req ? (!cfg_sel ? 3 : cfg_we ? 4 : 5) : io_we ? 6 : 7;
      a = rom_req ? rom_addr : mem_req ? mem_addr : io_req ? {16'h0, io_addr} : 32'h0;
      d = mem_req ? (mem_we ? mem_wdata : 0) : cfg_req ? (cfg_we ? cfg_wdata : 0) : (io_req && io_we) ? {24'h0, io_wdata} : 0;
      if (rom_ack || mem_ack || cfg_ack || io_ack) begin
        rom_ack = 0; mem_ack = 0; cfg_ack = 0; io_ack = 0;
      end else if (nreq > 0) begin
        chk(nreq == 1, "R10", "requests raised together", 32'(nreq), 1);
        if (pend) chk(pend_k == k && pend_a == a, "R10", "request changed before ack", a, pend_a);
        if (wcnt < lat) begin
          wcnt++;
          pend = 1; pend_k = k; pend_a = a;
        end else begin
          txn_t e;
          pend = 0; wcnt = 0; lat = (lat + 1) % 3;
          if (exp_q.size() == 0) chk(0, tag, "unexpected handshake addr", a, 32'hFFFF_FFFF);
          else begin
            e = exp_q.pop_front();
            chk(e.k == k && e.a == a && e.d == d, tag,
                $sformatf("handshake kind %0d/%0d data %h/%h, addr", k, e.k, d, e.d), a, e.a);
          end
          case (k)
            0: begin rom_data = romb(a); rom_ack = 1; end
            1, 2: begin mem_rdata = mresp(a); mem_ack = 1; end
            3, 4, 5: begin
              if (k == 3) cfg_last = d;
              cfg_rdata = cresp(cfg_last); cfg_ack = 1;
            end
            default: begin io_rdata = iresp(a[15:0]); io_ack = 1; end
          endcase
        end
      end else pend = 0;
    end
  end

  task automatic run_prog(input string t);
    tag = t;
    build_expected();
    @(negedge clk) start = 1;
    @(negedge clk) start = 0;
    for (int i = 0; i < 20000 && !done; i++) @(negedge clk);
    chk(done == 1'b1, t, "done after exit", 32'(done), 1);
    chk(exp_q.size() == 0, t, "missing handshakes", 32'(exp_q.size()), 0);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_fail++;
      $display("FAIL watchdog expired actual=%0d expected<150000", cyc);
      $display("[TB] %0d tests run, %0d failed", n_chk + 1, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R9 reset state
    chk(done == 0, "R9", "done after reset", 32'(done), 0);
    chk(!(rom_req || mem_req || cfg_req || io_req), "R9", "request after reset", 32'(rom_req), 0);

    rom.delete(); // R1 entry address and byte order
    put(B, 8'h03, 32'h0000_0040, 32'h0403_0201);
    put(B + 9, 8'hEE, 0, 0);
    run_prog("R1");

    rom.delete(); // R3 masked read, plain write
    put(B, 8'h02, 32'hF123_4560, 0);
    put(B + 9, 8'h07, 32'h03, 32'h330);
    put(B + 18, 8'h03, 32'h1000_0004, 32'h600D_D00D);
    put(B + 27, 8'hEE, 0, 0);
    run_prog("R3");

    rom.delete(); // R6 accumulator and scratch
    put(B, 8'h06, 0, 32'h0F0F);
    put(B + 9, 8'h06, 32'hFF00, 32'h3);
    put(B + 18, 8'h07, 32'h03, 32'h320);
    put(B + 27, 8'h10, 0, 32'h5500);
    put(B + 36, 8'h10, 32'hFFFF_00FF, 32'h11);
    put(B + 45, 8'h07, 32'h03, 32'h324);
    put(B + 54, 8'h06, 32'hFFFF_FFFF, 0);
    put(B + 63, 8'h07, 32'h03, 32'h328);
    put(B + 72, 8'hEE, 0, 0);
    run_prog("R6");

    rom.delete(); // R1 restart clears accumulator (left nonzero above)
    put(B, 8'h07, 32'h03, 32'h350);
    put(B + 9, 8'hEE, 0, 0);
    run_prog("R1");

    rom.delete(); // R2 branches, forward and backward
    put(B, 8'h09, 0, 32'd9);
    put(B + 9, 8'h03, 32'h200, 32'hBAD);
    put(B + 18, 8'h06, 0, 32'h77);
    put(B + 27, 8'h08, 32'h77, 32'h100);
    put(B + 36, 8'h03, 32'h204, 32'h1);
    put(B + 45, 8'h08, 32'h78, 32'h100);
    put(B + 54, 8'h03, 32'h20C, 32'hBAD);
    put(B + 63, 8'hEE, 0, 0);
    put(B + 32'h136, 8'h03, 32'h208, 32'h2);
    put(B + 32'h13F, 8'h09, 0, (B + 32'd63) - (B + 32'h13F + 32'd9));
    run_prog("R2");

    rom.delete(); // R4 R5 configuration port, protected bit
    put(B, 8'h04, 32'h8000_0810, 32'hCAFE_F00D);
    put(B + 9, 8'h04, 32'h8000_0880, 32'hFFFF_FFFF);
    put(B + 18, 8'h05, 32'h8000_0808, 0);
    put(B + 27, 8'h07, 32'h03, 32'h300);
    put(B + 36, 8'h07, 32'h04, 32'h8000_0880);
    put(B + 45, 8'hEE, 0, 0);
    run_prog("R4");

    rom.delete(); // R5 read then branch on result
    put(B, 8'h05, 32'h8000_0004, 0);
    put(B + 9, 8'h08, ~32'h8000_0004 + 32'h11, 32'd9);
    put(B + 18, 8'h03, 32'h360, 32'h1);
    put(B + 27, 8'hEE, 0, 0);
    run_prog("R5");

    rom.delete(); // R7 byte I/O, zero extension
    put(B, 8'h11, 32'h0000_0080, 32'h1234_56AB);
    put(B + 9, 8'h12, 32'h61, 0);
    put(B + 18, 8'h07, 32'h03, 32'h310);
    put(B + 27, 8'h11, 32'hABCD_1234, 32'h5A);
    put(B + 36, 8'hEE, 0, 0);
    run_prog("R7");

    rom.delete(); // R8 prefix forms
    put(B, 8'h06, 0, 32'h8000_0880);
    put(B + 9, 8'h07, 32'h0000_0409, 32'h8000_0880);
    put(B + 18, 8'h07, 32'h06, 32'hF0);
    put(B + 27, 8'h07, 32'h03, 32'h370);
    put(B + 36, 8'hEE, 0, 0);
    run_prog("R8");

    rom.delete(); // R9 undefined opcodes are no-ops, exit holds done
    put(B, 8'h55, 32'h1, 32'h2);
    put(B + 9, 8'h00, 32'h3, 32'h4);
    put(B + 18, 8'hFF, 32'h5, 32'h6);
    put(B + 27, 8'h13, 32'h7, 32'h8);
    put(B + 36, 8'h07, 32'h03, 32'h340);
    put(B + 45, 8'hEE, 0, 0);
    run_prog("R9");
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      chk(done && !(rom_req || mem_req || cfg_req || io_req), "R9", "done held quiet", 32'(done), 1);
    end

    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule